// File: doc/BRIEF.md
# Nine-bit three-wire display serializer

This block drives a display controller over a three-wire serial link that has no separate pin to tell commands from data. Each byte offered at the input, together with a command flag, leaves the block as a 9-bit word: a leading type bit, then the eight payload bits, most significant first. Words follow one another with no idle bits between them, so word boundaries drift across byte boundaries of the stream.

A burst is a run of bytes closed by an input marked as last. The chip select stays asserted for the whole burst. It may only be released once the number of clocked bits is a multiple of eight. When the burst ends off such a boundary, the block appends whole command words carrying a padding opcode until it lands on one. Each word adds one bit modulo eight, so at most seven padding words are needed. The serial clock is a mode 0 clock produced from the system clock by a parameterised divider.

Top module: `dc9_serializer`

## Requirements
- R1: Every word is 9 bits long: the type bit goes out first, then the payload byte from bit 7 down to bit 0.
- R2: The type bit is 0 for a byte offered with `in_is_cmd` high and 1 for a byte offered with `in_is_cmd` low.
- R3: Words of one burst are sent back to back, and only whole words are ever sent. If the input pauses between words, the clock stays low and no extra bits are clocked.
- R4: After the word marked `in_last`, the block appends command words (type bit 0, payload `PAD_OP`, default 8'h5C) until the burst holds a multiple of 8 words. The burst then carries a multiple of 8 bits.
- R5: The link runs in mode 0. `sclk` is low whenever `cs_n` is high, and `mosi` changes only while `sclk` is low, so it is stable at every rising edge.
- R6: Each high phase of `sclk` lasts exactly `HALF_DIV` system clock cycles.
- R7: `cs_n` falls before the first rising edge of a burst and stays low for the whole burst, including input pauses. It rises only after the last padding bit, with `sclk` low, when the number of rising edges in the burst is a multiple of 8.
- R8: `in_ready` is high when idle and between words of a burst. It is low from the cycle after a byte is accepted until that word has been fully shifted out.
- R9: `busy` is high from the cycle after the first byte of a burst is accepted until `cs_n` is released, and it is high whenever `cs_n` is low.
- R10: After reset, `cs_n` is 1, `sclk` is 0, `mosi` is 0, `busy` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte this cycle |
| in_byte | input | 8 | Payload byte |
| in_is_cmd | input | 1 | High for a command byte, low for a data byte |
| in_last | input | 1 | The byte closes the current burst |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | A burst is in progress |

## Verification
The assertions assume that the input handshake is well formed. The offered byte, flag and last marker stay steady while `in_valid` is high and `in_ready` is low, and every burst is eventually closed by an input marked last. The stimulus meets this because one task offers a byte, holds it until it is taken, and takes every byte from a table in which each burst ends on a last-marked entry. The edge-count check on chip-select release also assumes that reset does not arrive mid-burst, and the stimulus applies reset only at the start.

// File: rtl/dc9_pkg.sv
package dc9_pkg;
  localparam int WORD_W = 9;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_TAIL  = 2'd3
  } dc9_state_t;
endpackage

// File: rtl/dc9_tick.sv
// Half-period strobe generator for the serial clock.
module dc9_tick #(
  parameter int HALF_DIV = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/dc9_shifter.sv
// Shifts one word MSB first in mode 0; pulses done after the last high phase.
module dc9_shifter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] word,
  input  logic         tick,
  output logic         sclk,
  output logic         mosi,
  output logic         active,
  output logic         done
);
  localparam int BW = $clog2(W);
  localparam logic [BW-1:0] LASTBIT = BW'(W - 1);

  logic [W-1:0]  sh;
  logic [BW-1:0] bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      sclk   <= 1'b0;
      active <= 1'b0;
      done   <= 1'b0;
      bits   <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        sh     <= word;
        sclk   <= 1'b0;
        active <= 1'b1;
        bits   <= '0;
      end else if (active && tick) begin
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (bits == LASTBIT) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            sh   <= {sh[W-2:0], 1'b0};
            bits <= bits + 1'b1;
          end
        end
      end
    end
  end

  assign mosi = sh[W-1];
endmodule

// File: rtl/dc9_align.sv
// Tracks the burst bit count modulo the byte width.
module dc9_align #(
  parameter int W      = 9,
  parameter int BYTE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic aligned
);
  localparam int MW = $clog2(BYTE_W);
  localparam logic [MW-1:0] STEP = MW'(W % BYTE_W);

  logic [MW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (clear && step) begin
      phase <= STEP;
    end else if (clear) begin
      phase <= '0;
    end else if (step) begin
      phase <= phase + STEP;
    end
  end

  assign aligned = (phase == '0);
endmodule

// File: rtl/dc9_serializer.sv
module dc9_serializer #(
  parameter int         HALF_DIV = 13,
  parameter logic [7:0] PAD_OP   = 8'h5C
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_byte,
  input  logic       in_is_cmd,
  input  logic       in_last,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       busy
);
  import dc9_pkg::*;
  localparam int W = WORD_W;

  dc9_state_t state;
  logic       last_q;
  logic       accept, pad_load, load;
  logic [W-1:0] word_in;
  logic       tick, sh_active, sh_done, aligned;

  assign in_ready = (state == ST_IDLE) || (state == ST_GAP);
  assign accept   = in_valid && in_ready;
  assign pad_load = (state == ST_SHIFT) && sh_done && last_q && !aligned;
  assign load     = accept || pad_load;
  assign word_in  = pad_load ? {1'b0, PAD_OP} : {~in_is_cmd, in_byte};
  assign busy     = (state != ST_IDLE);

  dc9_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (sh_active || (state == ST_TAIL)),
    .tick (tick)
  );

  dc9_shifter #(.W(W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .word   (word_in),
    .tick   (tick),
    .sclk   (sclk),
    .mosi   (mosi),
    .active (sh_active),
    .done   (sh_done)
  );

  dc9_align #(.W(W), .BYTE_W(BYTE_W)) u_align (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept && (state == ST_IDLE)),
    .step    (load),
    .aligned (aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cs_n   <= 1'b1;
      last_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_SHIFT;
          cs_n   <= 1'b0;
          last_q <= in_last;
        end
        ST_SHIFT: if (sh_done) begin
          if (!last_q)      state <= ST_GAP;
          else if (aligned) state <= ST_TAIL;
        end
        ST_GAP: if (accept) begin
          state  <= ST_SHIFT;
          last_q <= in_last;
        end
        default: if (tick) begin
          state <= ST_IDLE;
          cs_n  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/dc9_serializer_chk.sv
module dc9_serializer_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic busy
);
  logic       sclk_d;
  logic [2:0] edges;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      edges  <= '0;
    end else begin
      sclk_d <= sclk;
      if (cs_n)                edges <= '0;
      else if (sclk && !sclk_d) edges <= edges + 1'b1;
    end
  end

  // R5
  mosi_steady_chk: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));
  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);
  // R7
  cs_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (edges == 3'd0) && !sclk);
  // R7
  cs_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !sclk);
  // R8
  ready_low_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !sclk);
  // R8
  take_once_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  // R9
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);
endmodule

bind dc9_serializer dc9_serializer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .sclk     (sclk),
  .mosi     (mosi),
  .cs_n     (cs_n),
  .busy     (busy)
);

// File: tb/dc9_serializer_test.sv
`timescale 1ns/1ps
module dc9_serializer_test;
  localparam int         HALF = 13;
  localparam logic [7:0] PAD  = 8'h5C;
  localparam int         NV   = 30;
  localparam int         LIMIT = 150000;

  // {is_cmd, last, byte}
  localparam logic [9:0] VEC [NV] = '{
    {2'b10, 8'h15}, {2'b00, 8'h00}, {2'b01, 8'h7F},
    {2'b11, 8'hAF},
    {2'b10, 8'h75}, {2'b00, 8'h10}, {2'b00, 8'h20}, {2'b00, 8'h30},
    {2'b00, 8'h40}, {2'b00, 8'h50}, {2'b00, 8'h60}, {2'b01, 8'h70},
    {2'b10, 8'hA0}, {2'b00, 8'h11}, {2'b00, 8'h22}, {2'b00, 8'h33},
    {2'b00, 8'h44}, {2'b00, 8'h55}, {2'b00, 8'h66}, {2'b00, 8'h77},
    {2'b00, 8'h88}, {2'b00, 8'h99}, {2'b00, 8'hAA}, {2'b00, 8'hBB},
    {2'b00, 8'hCC}, {2'b00, 8'hDD}, {2'b00, 8'hEE}, {2'b01, 8'hFF},
    {2'b00, 8'hFF}, {2'b01, 8'h01}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_is_cmd = 1'b0, in_last = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic in_ready, sclk, mosi, cs_n, busy;

  always #2 clk = ~clk;

  dc9_serializer #(.HALF_DIV(HALF), .PAD_OP(PAD)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .in_is_cmd(in_is_cmd), .in_last(in_last),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy)
  );

  int n_chk = 0, n_err = 0;
  logic [8:0] exp_w [64];
  int exp_bits [8];
  int ne = 0, nb = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // Monitor: decode MOSI into words at rising SCLK edges.
  bit mon_en = 0;
  logic sclk_p = 0, cs_p = 1;
  logic [8:0] acc = '0;
  int in_word = 0, burst_bits = 0, hi_len = 0, widx = 0, bidx = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (sclk && !sclk_p) begin
        acc = {acc[7:0], mosi};
        in_word++;
        burst_bits++;
        if (in_word == 9) begin
          chk("R2 type bit", {31'd0, acc[8]}, {31'd0, exp_w[widx][8]});
          chk("R1 payload", {24'd0, acc[7:0]}, {24'd0, exp_w[widx][7:0]});
          widx++;
          in_word = 0;
        end
      end
      if (sclk) hi_len++;
      if (!sclk && sclk_p) begin
        chk("R6 high phase", hi_len, HALF);
        hi_len = 0;
      end
      if (sclk) chk("R8 ready low while shifting", {31'd0, in_ready}, 32'd0);
      if (!cs_n) chk("R9 busy during burst", {31'd0, busy}, 32'd1);
      if (cs_n) chk("R5 clock idles low", {31'd0, sclk}, 32'd0);
      if (cs_n && !cs_p) begin
        chk("R4 burst bit count", burst_bits, exp_bits[bidx]);
        chk("R7 byte boundary", burst_bits % 8, 0);
        chk("R3 whole words only", in_word, 0);
        bidx++;
        burst_bits = 0;
      end
      sclk_p = sclk;
      cs_p   = cs_n;
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic send(input logic [9:0] v);
    @(negedge clk);
    in_valid  = 1'b1;
    in_is_cmd = v[9];
    in_last   = v[8];
    in_byte   = v[7:0];
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 ready drops after accept", {31'd0, in_ready}, 32'd0);
    chk("R9 busy after accept", {31'd0, busy}, 32'd1);
  endtask

  initial begin
    int wc = 0;
    for (int i = 0; i < NV; i++) begin
      exp_w[ne] = {~VEC[i][9], VEC[i][7:0]};
      ne++;
      wc++;
      if (VEC[i][8]) begin
        while (wc % 8 != 0) begin
          exp_w[ne] = {1'b0, PAD};
          ne++;
          wc++;
        end
        exp_bits[nb] = wc * 9;
        nb++;
        wc = 0;
      end
    end

    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 cs_n", {31'd0, cs_n}, 32'd1);
    chk("R10 sclk", {31'd0, sclk}, 32'd0);
    chk("R10 mosi", {31'd0, mosi}, 32'd0);
    chk("R10 busy", {31'd0, busy}, 32'd0);
    chk("R10 in_ready", {31'd0, in_ready}, 32'd1);
    mon_en = 1;

    for (int i = 0; i < NV; i++) begin
      if (i == 6) begin
        // pause mid-burst: link must hold with clock low and select asserted
        while (!in_ready) @(negedge clk);
        repeat (40) @(negedge clk);
        chk("R7 select held in pause", {31'd0, cs_n}, 32'd0);
        chk("R3 clock stopped in pause", {31'd0, sclk}, 32'd0);
        chk("R8 ready between words", {31'd0, in_ready}, 32'd1);
      end
      send(VEC[i]);
    end

    while (busy || !cs_n) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R1 all words seen", widx, ne);
    chk("R4 all bursts closed", bidx, nb);
    chk("R9 idle after bursts", {31'd0, busy}, 32'd0);
    chk("R8 ready when idle", {31'd0, in_ready}, 32'd1);
    summary();
  end
endmodule